// File: doc/BRIEF.md
# Erase and Program Range Decoder

This block sits behind the serial front-end of a flash array. It watches one transaction at a time as a byte stream framed by a start strobe and an end strobe. The first byte is the command and the next three bytes are a 24-bit address. For the four erase commands and the page-program command, it works out which aligned region of the 512 KiB array the command would change.

When the transaction closes with a legal length, the block checks the region against an 11-entry sector lock map. The lock map is enforced only while the write-protect input is driven low. The block then issues a one-cycle verdict pulse, either go or reject. With that pulse it presents the operation kind and the inclusive start and end addresses. Those outputs hold until the next verdict.

Transactions of the wrong length, unknown commands and end strobes with no open transaction leave the outputs untouched. The array timing and any status reporting belong to other blocks.

Top module: `erase_range_decoder`

## Requirements
- R1: After reset, `go_o` and `reject_o` are 0 and `op_o`, `start_o` and `end_o` are all 0.
- R2: Commands 20h, 52h, D8h and 81h erase an aligned region of 4 KiB, 32 KiB, 64 KiB and 256 bytes, and report `op_o` 0, 1, 2 and 3 respectively. `start_o` is the address with the low log2(size) bits cleared, and `end_o` is `start_o` + size − 1.
- R3: Command 02h (program) reports `op_o` = 4 and the 256-byte page that holds the address. `start_o` has its low 8 bits cleared and `end_o` has its low 8 bits set.
- R4: An erase command reaches a verdict only when exactly 4 bytes (command plus three address bytes, most significant first) arrive between the strobes. With 3 or 5 bytes there is no pulse and the outputs are unchanged.
- R5: A program command needs at least 5 bytes. With only 4 bytes there is no pulse and the outputs are unchanged.
- R6: Any command byte other than the five above produces no pulse and leaves the outputs unchanged.
- R7: Address bits 23..19 are ignored. `start_o` and `end_o` always lie in 000000h..07FFFFh, with bits 23..19 reported as 0.
- R8: The sector map is as follows. Sectors 0..6 are 64 KiB each, starting at index × 10000h. Sector 7 spans 70000h..77FFFh, sector 8 spans 78000h..79FFFh, sector 9 spans 7A000h..7BFFFh and sector 10 spans 7C000h..7FFFFh. Bit i of `sect_lock_i` locks sector i. With `wp_ni` = 0, the verdict is reject if any locked sector overlaps [start, end], and go otherwise.
- R9: With `wp_ni` = 1, every legal command gets go, whatever the lock map holds.
- R10: The verdict pulse is high in the one cycle after the clock edge that samples `eof_i`, and is low again in the following cycle.
- R11: An end strobe with no transaction opened by `sof_i` since the last end strobe produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | Transaction start strobe (chip select falling) |
| eof_i | input | 1 | Transaction end strobe (chip select rising) |
| byte_vld_i | input | 1 | `byte_i` holds a received byte this cycle |
| byte_i | input | 8 | Received byte |
| wp_ni | input | 1 | Write-protect level, low enables the lock map |
| sect_lock_i | input | 11 | Per-sector lock bits, bit i for sector i |
| go_o | output | 1 | Verdict pulse: command may proceed |
| reject_o | output | 1 | Verdict pulse: command touches a locked sector |
| op_o | output | 3 | Operation kind of the last verdict |
| start_o | output | 24 | First byte address of the affected region |
| end_o | output | 24 | Last byte address of the affected region |

## Verification
The main sweep visits every 4 KiB block of the array with each of the five commands, under both write-protect levels. The low address bits and the ignored high bits change on every run. That separates masking at each granularity from plain truncation, and it shows whether the top address bits leak into the range. A single lock bit walks through the map with the sweep, so each region is checked against a lock inside, below and above it. Regions that cross the 64K/32K/8K/16K sector boundaries at the top of memory tell apart a correct overlap test from one that looks only at the sector of the start address. Directed runs cover short, long and unknown commands and stray end strobes, and confirm that the outputs stay where they were.

// File: rtl/erd_pkg.sv
package erd_pkg;
  localparam int ADDR_W     = 24;
  localparam int MEM_AW     = 19;
  localparam int NUM_SECT   = 11;
  localparam int FULL_SECT  = 7;
  localparam int FULL_AW    = 16;
  localparam int HDR_BYTES  = 1 + ADDR_W / 8;
  localparam int CNT_SAT    = HDR_BYTES + 1;
  localparam int CNT_W      = $clog2(CNT_SAT + 1);

  localparam logic [7:0] OPC_ERASE_4K   = 8'h20;
  localparam logic [7:0] OPC_ERASE_32K  = 8'h52;
  localparam logic [7:0] OPC_ERASE_64K  = 8'hD8;
  localparam logic [7:0] OPC_ERASE_PAGE = 8'h81;
  localparam logic [7:0] OPC_PROGRAM    = 8'h02;

  typedef enum logic [2:0] {
    OP_ERASE_4K   = 3'd0,
    OP_ERASE_32K  = 3'd1,
    OP_ERASE_64K  = 3'd2,
    OP_ERASE_PAGE = 3'd3,
    OP_PROGRAM    = 3'd4,
    OP_NONE       = 3'd7
  } op_e;

  function automatic logic [MEM_AW-1:0] sect_base(int idx);
    if (idx < FULL_SECT) return MEM_AW'(idx) << FULL_AW;
    case (idx)
      7:       return MEM_AW'(32'h70000);
      8:       return MEM_AW'(32'h78000);
      9:       return MEM_AW'(32'h7A000);
      default: return MEM_AW'(32'h7C000);
    endcase
  endfunction

  function automatic logic [MEM_AW-1:0] sect_last(int idx);
    if (idx >= NUM_SECT - 1) return '1;
    return sect_base(idx + 1) - MEM_AW'(1);
  endfunction

  function automatic int span_bits(op_e op);
    case (op)
      OP_ERASE_4K:   return 12;
      OP_ERASE_32K:  return 15;
      OP_ERASE_64K:  return 16;
      OP_ERASE_PAGE,
      OP_PROGRAM:    return 8;
      default:       return 0;
    endcase
  endfunction
endpackage

// File: rtl/erd_capture.sv
module erd_capture
  import erd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sof_i,
  input  logic              eof_i,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  output logic [7:0]        opc_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              active_o
);
  logic [7:0]        opc_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opc_q    <= '0;
      addr_q   <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (sof_i) begin
      cnt_q    <= '0;
      active_q <= 1'b1;
    end else begin
      if (eof_i) active_q <= 1'b0;
      if (byte_vld_i && active_q && cnt_q != CNT_W'(CNT_SAT)) begin
        cnt_q <= cnt_q + CNT_W'(1);
        if (cnt_q == '0) opc_q <= byte_i;
        else if (cnt_q < CNT_W'(HDR_BYTES)) addr_q <= {addr_q[ADDR_W-9:0], byte_i};
      end
    end
  end

  assign opc_o    = opc_q;
  assign addr_o   = addr_q;
  assign cnt_o    = cnt_q;
  assign active_o = active_q;

  // R4: counter saturates just past the header
  p_cnt_sat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(CNT_SAT));
  // R11: start strobe opens a fresh transaction
  p_sof_opens_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> (active_q && cnt_q == '0));
endmodule

// File: rtl/erd_range.sv
module erd_range
  import erd_pkg::*;
(
  input  logic [7:0]        opc_i,
  input  logic [ADDR_W-1:0] addr_i,
  output op_e               op_o,
  output logic              known_o,
  output logic [MEM_AW-1:0] start_o,
  output logic [MEM_AW-1:0] end_o
);
  logic [MEM_AW-1:0] mask;

  always_comb begin
    case (opc_i)
      OPC_ERASE_4K:   op_o = OP_ERASE_4K;
      OPC_ERASE_32K:  op_o = OP_ERASE_32K;
      OPC_ERASE_64K:  op_o = OP_ERASE_64K;
      OPC_ERASE_PAGE: op_o = OP_ERASE_PAGE;
      OPC_PROGRAM:    op_o = OP_PROGRAM;
      default:        op_o = OP_NONE;
    endcase
  end

  assign known_o = (op_o != OP_NONE);
  assign mask    = (MEM_AW'(1) << span_bits(op_o)) - MEM_AW'(1);
  // upper address bits beyond the array are dropped here
  assign start_o = addr_i[MEM_AW-1:0] & ~mask;
  assign end_o   = start_o | mask;
endmodule

// File: rtl/erd_guard.sv
module erd_guard
  import erd_pkg::*;
(
  input  logic [MEM_AW-1:0]   start_i,
  input  logic [MEM_AW-1:0]   end_i,
  input  logic                wp_ni,
  input  logic [NUM_SECT-1:0] lock_i,
  output logic                blocked_o
);
  logic [NUM_SECT-1:0] hit;

  for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
    localparam logic [MEM_AW-1:0] BASE = sect_base(s);
    localparam logic [MEM_AW-1:0] LAST = sect_last(s);
    assign hit[s] = lock_i[s] && (start_i <= LAST) && (end_i >= BASE);
  end

  assign blocked_o = !wp_ni && (|hit);
endmodule

// File: rtl/erase_range_decoder.sv
module erase_range_decoder
  import erd_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sof_i,
  input  logic                eof_i,
  input  logic                byte_vld_i,
  input  logic [7:0]          byte_i,
  input  logic                wp_ni,
  input  logic [NUM_SECT-1:0] sect_lock_i,
  output logic                go_o,
  output logic                reject_o,
  output logic [2:0]          op_o,
  output logic [ADDR_W-1:0]   start_o,
  output logic [ADDR_W-1:0]   end_o
);
  logic [7:0]        opc;
  logic [ADDR_W-1:0] addr;
  logic [CNT_W-1:0]  cnt;
  logic              active;
  op_e               op;
  logic              known;
  logic [MEM_AW-1:0] rng_start, rng_end;
  logic              blocked;
  logic              len_ok, decide;

  logic              go_q, rej_q;
  logic [2:0]        op_q;
  logic [MEM_AW-1:0] start_q, end_q;

  erd_capture u_capture (
    .clk_i, .rst_ni, .sof_i, .eof_i, .byte_vld_i, .byte_i,
    .opc_o(opc), .addr_o(addr), .cnt_o(cnt), .active_o(active)
  );

  erd_range u_range (
    .opc_i(opc), .addr_i(addr), .op_o(op), .known_o(known),
    .start_o(rng_start), .end_o(rng_end)
  );

  erd_guard u_guard (
    .start_i(rng_start), .end_i(rng_end), .wp_ni,
    .lock_i(sect_lock_i), .blocked_o(blocked)
  );

  assign len_ok = (op == OP_PROGRAM) ? (cnt == CNT_W'(CNT_SAT))
                                     : (cnt == CNT_W'(HDR_BYTES));
  assign decide = active && eof_i && !sof_i && known && len_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      go_q    <= 1'b0;
      rej_q   <= 1'b0;
      op_q    <= '0;
      start_q <= '0;
      end_q   <= '0;
    end else begin
      go_q  <= decide && !blocked;
      rej_q <= decide && blocked;
      if (decide) begin
        op_q    <= op;
        start_q <= rng_start;
        end_q   <= rng_end;
      end
    end
  end

  assign go_o     = go_q;
  assign reject_o = rej_q;
  assign op_o     = op_q;
  assign start_o  = ADDR_W'(start_q);
  assign end_o    = ADDR_W'(end_q);

  p_one_verdict_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(go_o && reject_o));
  p_after_eof_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_o || reject_o) |-> $past(eof_i));
  p_single_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_o || reject_o) |=> !(go_o || reject_o));
  p_wp_open_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o |-> !$past(wp_ni));
  p_page_aligned_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_o || reject_o) |-> (start_o[7:0] == 8'h00 && end_o[7:0] == 8'hFF));
  p_in_array_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_o || reject_o) |-> (end_o[ADDR_W-1:MEM_AW] == '0 && start_o <= end_o));
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(go_o || reject_o) |-> $stable(start_o));
endmodule

// File: tb/erase_range_decoder_test.sv
module erase_range_decoder_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sof = 1'b0, eof = 1'b0, vld = 1'b0;
  logic [7:0]  bdat = '0;
  logic        wp_n = 1'b1;
  logic [10:0] lock = '0;
  logic        go, rej;
  logic [2:0]  op;
  logic [23:0] st, en;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  erase_range_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .sof_i(sof), .eof_i(eof),
    .byte_vld_i(vld), .byte_i(bdat), .wp_ni(wp_n), .sect_lock_i(lock),
    .go_o(go), .reject_o(rej), .op_o(op), .start_o(st), .end_o(en)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int sec_of(int a);
    if (a < 'h70000) return a / 'h10000;
    if (a < 'h78000) return 7;
    if (a < 'h7A000) return 8;
    if (a < 'h7C000) return 9;
    return 10;
  endfunction

  task automatic xfer(input logic [7:0] opc, input logic [23:0] addr, input int nb,
                      input logic wp, input logic [10:0] lk);
    wp_n = wp;
    lock = lk;
    @(negedge clk); sof = 1'b1;
    @(negedge clk); sof = 1'b0;
    for (int i = 0; i < nb; i++) begin
      vld  = 1'b1;
      bdat = (i == 0) ? opc : (i == 1) ? addr[23:16] : (i == 2) ? addr[15:8] :
             (i == 3) ? addr[7:0] : 8'(8'hA0 + i);
      @(negedge clk);
    end
    vld = 1'b0;
    eof = 1'b1;
    @(negedge clk); eof = 1'b0;
  endtask

  // expect one verdict with given range; caller is at the sampling negedge
  task automatic expect_verdict(input string req, input logic [2:0] eop,
                                input int es, input int ee, input bit eblk);
    chk(go == !eblk && rej == eblk, req, "verdict go/rej", {30'd0, go, rej},
        {30'd0, !eblk, eblk});
    chk(op == eop, req, "op", 32'(op), 32'(eop));
    chk(st == 24'(es) && en == 24'(ee), req, "range", {st[15:0], en[15:0]},
        {es[15:0], ee[15:0]});
  endtask

  task automatic expect_silent(input string req, input logic [23:0] prev_st);
    chk(!go && !rej && st == prev_st, req, "no verdict, outputs held",
        {6'd0, go, rej, st}, {8'd0, prev_st});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] opcs [5];
    int         bits [5];
    logic [23:0] prev;
    opcs = '{8'h20, 8'h52, 8'hD8, 8'h81, 8'h02};
    bits = '{12, 15, 16, 8, 8};

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!go && !rej && op == 0 && st == 0 && en == 0, "R1", "reset outputs",
        {go, rej, op, st[7:0]}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R7 R8 R9 sweep
    for (int blk = 0; blk < 128; blk++) begin
      for (int k = 0; k < 5; k++) begin
        for (int w = 0; w < 2; w++) begin
          int a, a19, msk, s, e, nb;
          bit blk_exp;
          logic [10:0] lk;
          a   = (((blk * 7 + k + w) & 31) << 19) | (blk << 12) | ((blk * 1237 + k * 611 + w * 97) & 'hFFF);
          a19 = a & 'h7FFFF;
          msk = (1 << bits[k]) - 1;
          s   = a19 & ~msk;
          e   = s + msk;
          lk  = (blk % 13 == 0) ? 11'd0 : 11'(1) << ((blk + k) % 11);
          nb  = (k == 4) ? 5 + (blk % 3) : 4;
          blk_exp = 1'b0;
          if (w == 0)
            for (int q = sec_of(s); q <= sec_of(e); q++) if (lk[q]) blk_exp = 1'b1;
          xfer(opcs[k], 24'(a), nb, w[0], lk);
          expect_verdict((k == 4) ? "R3" : (w == 1 ? "R9" : "R8"), 3'(k), s, e, blk_exp);
          @(negedge clk);
          chk(!go && !rej, "R10", "pulse single cycle", {30'd0, go, rej}, 32'd0);
        end
      end
    end

    // R8 boundary cases at top of memory
    xfer(8'hD8, 24'h070123, 4, 1'b0, 11'h400);
    expect_verdict("R8", 3'd2, 'h70000, 'h7FFFF, 1'b1);
    xfer(8'h52, 24'h07A456, 4, 1'b0, 11'h080);
    expect_verdict("R8", 3'd1, 'h78000, 'h7FFFF, 1'b0);
    xfer(8'h81, 24'h07BF33, 4, 1'b0, 11'h200);
    expect_verdict("R8", 3'd3, 'h7BF00, 'h7BFFF, 1'b1);
    xfer(8'h81, 24'h07BF33, 4, 1'b0, 11'h100);
    expect_verdict("R8", 3'd3, 'h7BF00, 'h7BFFF, 1'b0);
    xfer(8'h20, 24'h06FFFF, 4, 1'b0, 11'h080);
    expect_verdict("R8", 3'd0, 'h6F000, 'h6FFFF, 1'b0);

    // R7 top bits ignored
    xfer(8'h20, 24'hFFFFFF, 4, 1'b1, 11'h7FF);
    expect_verdict("R7", 3'd0, 'h7F000, 'h7FFFF, 1'b0);
    prev = st;

    // R4 erase lengths 3 and 5
    xfer(8'h20, 24'h012345, 3, 1'b1, 11'h0);
    expect_silent("R4", prev);
    xfer(8'hD8, 24'h012345, 5, 1'b1, 11'h0);
    expect_silent("R4", prev);
    // R5 program with only header
    xfer(8'h02, 24'h012345, 4, 1'b1, 11'h0);
    expect_silent("R5", prev);
    // R6 unknown commands
    xfer(8'h03, 24'h012345, 4, 1'b1, 11'h0);
    expect_silent("R6", prev);
    xfer(8'h03, 24'h012345, 6, 1'b1, 11'h0);
    expect_silent("R6", prev);
    // R11 stray end strobe after a legal erase
    xfer(8'h20, 24'h012345, 4, 1'b1, 11'h0);
    expect_verdict("R2", 3'd0, 'h12000, 'h12FFF, 1'b0);
    prev = st;
    eof = 1'b1;
    @(negedge clk); eof = 1'b0;
    expect_silent("R11", prev);

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule